// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates fifteen interrupt sources for a small 8-bit CPU core and hands the core one vector address at a time. Each source has an enable bit and a priority bit that places it at the high or the low level. Within a level, the fixed order is by source index. A global enable masks every source. Some sources are built from several raw peripheral flags ORed together. The block keeps a two-bit in-service record, one bit per level, so a high-level handler can nest inside a low-level one. It pulses a clear strobe for the sources whose flags the hardware clears when their vector is taken.

The CPU is modelled only by three handshake inputs. `insn_bnd` marks an instruction boundary. `vec_ack` says that the core has taken the presented vector. `reti` marks the boundary at which a return-from-interrupt instruction completes. Arbitration samples the sources only at an instruction boundary. One cycle later the block raises `irq_req` with the vector `0x0003 + 8*n`. Both are held until the acknowledge. Reset has its own fixed entry at address 0 in the core and is not routed through this block.

Top module: `vic_top`

## Requirements
- R1: For winning source n, `irq_vec` equals 0x0003 + 8*n, and `irq_req` rises in the cycle after the sampled `insn_bnd`.
- R2: Among eligible requests at the same level, the lowest source index wins.
- R3: An eligible high-level request (priority bit 1) wins over any low-level request, whatever the indices.
- R4: Source n is eligible only when its pending flag is set and its enable bit is set. For n < 7 the enable bit is `ie_base[n]`; for n >= 7 it is `ie_ext[n-7]`. `ie_base[7]` is the global enable, and when it is 0 no source is eligible. Priority bits are `ip_base[n]` (n < 7) and `ip_ext[n-7]`.
- R5: The raw flags map to sources as follows. Raw 0..3 drive sources 0..3. Raw 4 and raw 5 are ORed into source 4. Raw 6 drives source 5. Raw 7..10 are ORed into source 6. Raw 11..18 drive sources 7..14.
- R6: While `irq_req` is high and no acknowledge arrives, `irq_req` and `irq_vec` stay unchanged, even across further boundaries and new requests.
- R7: When `vec_ack` is asserted while a request is presented, `irq_req` is low in the next cycle and the `in_svc` bit for the vector's level (bit 1 high, bit 0 low) is set. For sources 0..3, `flag_clr[n]` pulses for exactly that next cycle; other sources get no clear pulse.
- R8: If a high-level handler is in service, no request is presented. If only a low-level handler is in service, only high-level requests are presented.
- R9: `reti` clears the highest set `in_svc` bit and leaves the lower bit unchanged.
- R10: A boundary that coincides with `reti` is not sampled; the first boundary after it is sampled.
- R11: Pending flags with no `insn_bnd` never raise `irq_req`.
- R12: After reset, `irq_req`, `in_svc` and `flag_clr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_flag | input | 19 | Raw peripheral pending flags, merged per R5 |
| ie_base | input | 8 | Enables of sources 0..6, bit 7 global enable |
| ie_ext | input | 8 | Enables of sources 7..14 |
| ip_base | input | 7 | Priority bits of sources 0..6 |
| ip_ext | input | 8 | Priority bits of sources 7..14 |
| insn_bnd | input | 1 | Instruction boundary strobe |
| vec_ack | input | 1 | CPU has taken the presented vector |
| reti | input | 1 | Return-from-interrupt completes at this boundary |
| irq_req | output | 1 | Vector request to the CPU |
| irq_vec | output | 16 | Vector address of the presented request |
| flag_clr | output | 15 | One-cycle hardware clear strobe, one bit per source |
| in_svc | output | 2 | In-service levels, bit 1 high, bit 0 low |

## Verification
The hardest state to reach is two handlers nested: a low-level ISR in service, a high-level one taken on top of it, and then an ordered unwind in which each `reti` must drop exactly one level. Meanwhile a lower request waits and must not slip in at the `reti` boundary itself. The stimulus first takes a low-level vector. It raises a further low request, which has to be refused, and then a high request, which has to be presented. After two `reti` boundaries the waiting low request must appear only at the boundary after the last return. A separate sequence keeps a request unacknowledged across several boundaries while a higher source becomes pending, and checks that the vector does not move.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int NSRC     = 15;
    localparam int NBASE    = 7;
    localparam int NEXT     = NSRC - NBASE;
    localparam int NRAW     = 19;
    localparam int SW       = $clog2(NSRC);
    localparam int VW       = 16;
    localparam int NHWCLR   = 4;
    localparam int VEC_BASE = 3;
    localparam int VEC_STEP = 8;

    typedef struct packed {
        logic          valid;
        logic          lvl;
        logic [SW-1:0] idx;
    } pick_t;

    // raw flag index -> source index
    function automatic int src_of_raw(int r);
        if (r < 4)  return r;
        if (r < 6)  return 4;
        if (r == 6) return 5;
        if (r < 11) return 6;
        return r - 4;
    endfunction

    function automatic logic [VW-1:0] vec_of(logic [SW-1:0] n);
        return VW'(VEC_BASE + VEC_STEP * int'(n));
    endfunction

endpackage

// File: rtl/vic_gate.sv
module vic_gate
    import vic_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_BASE = NBASE,
    parameter int N_RAW  = NRAW
) (
    input  logic [N_RAW-1:0]        raw_flag,
    input  logic [N_BASE:0]         ie_base,
    input  logic [N_SRC-N_BASE-1:0] ie_ext,
    input  logic [N_BASE-1:0]       ip_base,
    input  logic [N_SRC-N_BASE-1:0] ip_ext,
    output logic [N_SRC-1:0]        elig,
    output logic [N_SRC-1:0]        lvl
);
    logic [N_SRC-1:0] merged;
    logic [N_SRC-1:0] en_all;

    // OR the raw flags of each merged group into one request line
    always_comb begin
        merged = '0;
        for (int r = 0; r < N_RAW; r++) begin
            merged[src_of_raw(r)] = merged[src_of_raw(r)] | raw_flag[r];
        end
    end

    assign en_all = {ie_ext, ie_base[N_BASE-1:0]};
    assign lvl    = {ip_ext, ip_base};
    assign elig   = merged & en_all & {N_SRC{ie_base[N_BASE]}};

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N_SRC = NSRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] elig,
    input  logic [N_SRC-1:0] lvl,
    input  logic [1:0]       svc,
    output pick_t            pick
);
    logic [N_SRC-1:0] hi_req, lo_req;
    logic             hi_any, lo_any;
    logic [SW-1:0]    hi_idx, lo_idx;
    logic             hi_ok, lo_ok;

    assign hi_req = elig & lvl;
    assign lo_req = elig & ~lvl;
    assign hi_ok  = !svc[1];
    assign lo_ok  = (svc == 2'b00);

    // scan downward so the lowest index is the last one written
    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_idx = '0;
        lo_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hi_req[i]) begin
                hi_any = 1'b1;
                hi_idx = SW'(i);
            end
            if (lo_req[i]) begin
                lo_any = 1'b1;
                lo_idx = SW'(i);
            end
        end
    end

    always_comb begin
        pick = '0;
        if (hi_any && hi_ok) begin
            pick.valid = 1'b1;
            pick.lvl   = 1'b1;
            pick.idx   = hi_idx;
        end else if (lo_any && lo_ok) begin
            pick.valid = 1'b1;
            pick.lvl   = 1'b0;
            pick.idx   = lo_idx;
        end
    end

    // R2: the chosen source really is eligible at the reported level
    a_r2_pick_is_eligible: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (elig[pick.idx] && (lvl[pick.idx] == pick.lvl)));

    // R3: a low-level pick only when no admissible high-level request exists
    a_r3_high_first: assert property (@(posedge clk) disable iff (rst)
        (pick.valid && !pick.lvl) |-> !((|(elig & lvl)) && !svc[1]));

endmodule

// File: rtl/vic_stack.sv
module vic_stack (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       take_lvl,
    input  logic       reti,
    output logic [1:0] svc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            svc <= 2'b00;
        end else if (take) begin
            svc[take_lvl] <= 1'b1;
        end else if (reti) begin
            if (svc[1]) svc[1] <= 1'b0;
            else        svc[0] <= 1'b0;
        end
    end

    // R8: a vector is only taken above every level already in service
    a_r8_take_above: assert property (@(posedge clk) disable iff (rst)
        take |-> (take_lvl ? !svc[1] : (svc == 2'b00)));

    // R9: return pops the high level first and keeps the low bit
    a_r9_pop_high: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && svc[1]) |=> (!svc[1] && (svc[0] == $past(svc[0]))));

    a_r9_pop_low: assert property (@(posedge clk) disable iff (rst)
        (reti && !take && !svc[1]) |=> (svc == 2'b00));

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_BASE = NBASE,
    parameter int N_RAW  = NRAW,
    parameter int N_HW   = NHWCLR
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_RAW-1:0]        raw_flag,
    input  logic [N_BASE:0]         ie_base,
    input  logic [N_SRC-N_BASE-1:0] ie_ext,
    input  logic [N_BASE-1:0]       ip_base,
    input  logic [N_SRC-N_BASE-1:0] ip_ext,
    input  logic                    insn_bnd,
    input  logic                    vec_ack,
    input  logic                    reti,
    output logic                    irq_req,
    output logic [VW-1:0]           irq_vec,
    output logic [N_SRC-1:0]        flag_clr,
    output logic [1:0]              in_svc
);
    logic [N_SRC-1:0] elig, lvl;
    pick_t            pick, pick_q;
    logic             pend_q;
    logic [N_SRC-1:0] clr_q;
    logic             sample, take;

    vic_gate #(.N_SRC(N_SRC), .N_BASE(N_BASE), .N_RAW(N_RAW)) u_gate (
        .raw_flag(raw_flag),
        .ie_base (ie_base),
        .ie_ext  (ie_ext),
        .ip_base (ip_base),
        .ip_ext  (ip_ext),
        .elig    (elig),
        .lvl     (lvl)
    );

    vic_arbiter #(.N_SRC(N_SRC)) u_arb (
        .clk (clk),
        .rst (rst),
        .elig(elig),
        .lvl (lvl),
        .svc (in_svc),
        .pick(pick)
    );

    assign sample = insn_bnd && !reti && !pend_q && pick.valid;
    assign take   = pend_q && vec_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            pick_q <= '0;
            clr_q  <= '0;
        end else begin
            clr_q <= '0;
            if (take) begin
                pend_q <= 1'b0;
                if (int'(pick_q.idx) < N_HW)
                    clr_q <= N_SRC'(1) << pick_q.idx;
            end else if (sample) begin
                pend_q <= 1'b1;
                pick_q <= pick;
            end
        end
    end

    vic_stack u_stack (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_lvl(pick_q.lvl),
        .reti    (reti),
        .svc     (in_svc)
    );

    assign irq_req  = pend_q;
    assign irq_vec  = pend_q ? vec_of(pick_q.idx) : '0;
    assign flag_clr = clr_q;

    // R6: presented vector holds until acknowledged
    a_r6_vec_hold: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !vec_ack) |=> (irq_req && $stable(irq_vec)));

    // R7: clear strobe is one-hot and only follows an acknowledge
    a_r7_clr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_clr));

    a_r7_clr_after_ack: assert property (@(posedge clk) disable iff (rst)
        (|flag_clr) |-> $past(irq_req && vec_ack));

    // R11: a request only appears after a boundary
    a_r11_req_at_bnd: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(insn_bnd && !reti));

endmodule

// File: tb/sim_vic_top.sv
module sim_vic_top;
    import vic_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NRAW-1:0]  raw_flag = '0;
    logic [NBASE:0]   ie_base = '0;
    logic [NEXT-1:0]  ie_ext = '0;
    logic [NBASE-1:0] ip_base = '0;
    logic [NEXT-1:0]  ip_ext = '0;
    logic             insn_bnd = 1'b0;
    logic             vec_ack = 1'b0;
    logic             reti = 1'b0;
    logic             irq_req;
    logic [VW-1:0]    irq_vec;
    logic [NSRC-1:0]  flag_clr;
    logic [1:0]       in_svc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic req_d = 1'b0;
    logic [VW-1:0] exp_q[$];

    always #2 clk = ~clk;

    vic_top u0 (
        .clk(clk), .rst(rst), .raw_flag(raw_flag), .ie_base(ie_base),
        .ie_ext(ie_ext), .ip_base(ip_base), .ip_ext(ip_ext),
        .insn_bnd(insn_bnd), .vec_ack(vec_ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .flag_clr(flag_clr),
        .in_svc(in_svc)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: each new request is compared with the scoreboard head
    always @(posedge clk) begin
        #1;
        if (!rst && irq_req && !req_d) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R1 unexpected request actual=0x%0h expected=none", irq_vec);
            end else begin
                chk("R1 vector", 32'(irq_vec), 32'(exp_q.pop_front()));
            end
        end
        req_d = irq_req;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic boundary(bit with_reti);
        insn_bnd = 1'b1;
        reti     = with_reti;
        tick();
        insn_bnd = 1'b0;
        reti     = 1'b0;
    endtask

    task automatic ack();
        vec_ack = 1'b1;
        tick();
        vec_ack = 1'b0;
    endtask

    task automatic expect_vec(int n);
        exp_q.push_back(VW'(3 + 8 * n));
    endtask

    task automatic drained(string tag);
        chk(tag, 32'(exp_q.size()), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk("R12 req in reset", 32'(irq_req), 0);
        rst = 1'b0;
        tick();
        chk("R12 req", 32'(irq_req), 0);
        chk("R12 in_svc", 32'(in_svc), 0);
        chk("R12 flag_clr", 32'(flag_clr), 0);

        // R11: flags without a boundary
        raw_flag[0] = 1'b1;
        ie_base = 8'h81;
        repeat (4) tick();
        chk("R11 no boundary", 32'(irq_req), 0);

        // R1, R7, R10: two low sources, hardware-cleared
        raw_flag[3] = 1'b1;
        ie_base = 8'h89;
        expect_vec(0);
        boundary(0);
        drained("R1 source 0");
        chk("R1 vec 0x0003", 32'(irq_vec), 32'h0003);
        ack();
        chk("R7 req drop", 32'(irq_req), 0);
        chk("R7 svc low", 32'(in_svc), 2'b01);
        chk("R7 hw clear src0", 32'(flag_clr), 32'h0001);
        tick();
        chk("R7 clear one cycle", 32'(flag_clr), 0);
        raw_flag[0] = 1'b0;
        boundary(1);
        chk("R9 svc after reti", 32'(in_svc), 0);
        chk("R10 no sample at reti", 32'(irq_req), 0);
        expect_vec(3);
        boundary(0);
        drained("R10 next boundary");
        ack();
        chk("R7 hw clear src3", 32'(flag_clr), 32'h0008);
        raw_flag[3] = 1'b0;
        boundary(1);

        // R3, R5, R8: merged tx flag at low, source 8 at high
        raw_flag[5]  = 1'b1;
        raw_flag[12] = 1'b1;
        ie_base = 8'h91;
        ie_ext  = 8'h02;
        ip_ext  = 8'h02;
        ip_base = 7'h01;
        expect_vec(8);
        boundary(0);
        drained("R3 high wins");
        ack();
        chk("R7 svc high", 32'(in_svc), 2'b10);
        chk("R7 no clear sw source", 32'(flag_clr), 0);
        raw_flag[12] = 1'b0;
        raw_flag[0]  = 1'b1;
        boundary(0);
        chk("R8 high blocked", 32'(irq_req), 0);
        boundary(1);
        chk("R10 reti boundary", 32'(irq_req), 0);
        expect_vec(0);
        boundary(0);
        drained("R3 high src0 over src4");
        ack();
        raw_flag[0] = 1'b0;
        boundary(1);
        expect_vec(4);
        boundary(0);
        drained("R5 tx flag merged");
        ack();
        chk("R7 no clear src4", 32'(flag_clr), 0);
        raw_flag[5] = 1'b0;
        boundary(1);

        // R8, R9: nesting with an SPI-group flag
        ie_base = 8'hC4;
        ie_ext  = 8'h08;
        ip_base = 7'h00;
        ip_ext  = 8'h08;
        raw_flag[9] = 1'b1;
        expect_vec(6);
        boundary(0);
        drained("R5 spi flag merged");
        ack();
        raw_flag[2] = 1'b1;
        boundary(0);
        chk("R8 low blocked by low", 32'(irq_req), 0);
        raw_flag[14] = 1'b1;
        expect_vec(10);
        boundary(0);
        drained("R8 high preempts low");
        ack();
        chk("R8 nested svc", 32'(in_svc), 2'b11);
        raw_flag[14] = 1'b0;
        boundary(1);
        chk("R9 pop high", 32'(in_svc), 2'b01);
        chk("R8 still blocked", 32'(irq_req), 0);
        raw_flag[9] = 1'b0;
        boundary(1);
        chk("R9 pop low", 32'(in_svc), 2'b00);
        chk("R10 held at reti", 32'(irq_req), 0);
        expect_vec(2);
        boundary(0);
        drained("R10 waiting low served");
        ack();
        chk("R7 hw clear src2", 32'(flag_clr), 32'h0004);
        raw_flag[2] = 1'b0;
        boundary(1);

        // R4: enables and global enable
        ip_ext = '0;
        raw_flag[1] = 1'b1;
        ie_base = 8'h80;
        ie_ext  = 8'h00;
        boundary(0);
        chk("R4 source disabled", 32'(irq_req), 0);
        ie_base = 8'h02;
        raw_flag[17] = 1'b1;
        ie_ext  = 8'h40;
        boundary(0);
        chk("R4 global off", 32'(irq_req), 0);
        raw_flag[18] = 1'b1;
        ie_base = 8'h80;
        ie_ext  = 8'h80;
        expect_vec(14);
        boundary(0);
        drained("R4 ext enable src14");
        chk("R1 vec 0x0073", 32'(irq_vec), 32'h0073);
        ack();
        boundary(1);
        raw_flag = '0;

        // R2: two high sources in the extended range
        raw_flag[11] = 1'b1;
        raw_flag[16] = 1'b1;
        ie_ext = 8'h21;
        ip_ext = 8'h21;
        expect_vec(7);
        boundary(0);
        drained("R2 lowest index");
        ack();
        raw_flag[11] = 1'b0;
        boundary(1);
        expect_vec(12);
        boundary(0);
        drained("R2 next index");
        ack();
        raw_flag[16] = 1'b0;
        boundary(1);
        ie_ext = '0;
        ip_ext = '0;

        // R6: vector held without acknowledge
        raw_flag[6] = 1'b1;
        ie_base = 8'hA0;
        expect_vec(5);
        boundary(0);
        drained("R6 first vector");
        raw_flag[0] = 1'b1;
        ie_base = 8'hA1;
        ip_base = 7'h01;
        boundary(0);
        boundary(0);
        chk("R6 req held", 32'(irq_req), 1);
        chk("R6 vec held", 32'(irq_vec), 32'h002B);
        ack();
        expect_vec(0);
        boundary(0);
        drained("R8 preempt after ack");
        ack();
        chk("R8 nested again", 32'(in_svc), 2'b11);
        chk("R7 hw clear nested", 32'(flag_clr), 32'h0001);
        raw_flag[0] = 1'b0;
        boundary(1);
        raw_flag[6] = 1'b0;
        boundary(1);
        chk("R9 unwound", 32'(in_svc), 0);
        repeat (3) tick();
        chk("R11 idle", 32'(irq_req), 0);
        drained("final queue");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule